// File: doc/BRIEF.md
# Command Ring Pointer Register Block

This block keeps the bookkeeping for a command ring buffer held in memory. Software sets the ring's start and last slot, the producer and consumer positions, two watermark levels and a breakpoint address through a 16-bit register bus. Each 32-bit value sits behind two consecutive addresses, one for each half. Writing the low half of an address-type register drops the five lowest bits so that every position stays on a 32-byte boundary.

Two strobes move the ring. A burst strobe says that a 32-byte block of commands has landed behind the producer position. The producer position then steps forward or folds back to the ring start, and the byte count grows by 32. This happens only while the link control bit is set. A consume strobe does the same for the consumer position and shrinks the byte count. A computed occupancy value gives the bytes outstanding between consumer and producer, and it is correct when the producer has folded back past the ring start. A high-half write to the byte count raises a one-cycle restart pulse. If the count ends up zero, a second pulse also asks the upstream gather pipe to restart. A block of counter addresses reads as fixed constants.

Top module: `cmdring_regs`

## Requirements
- R1: Pointer register k (k = 0 ring start, 1 ring last slot, 2 producer, 3 consumer, 4 byte count, 5 high watermark, 6 low watermark, 7 breakpoint) has its low half at address 2k and its high half at 2k+1. A low-half write replaces bits 15:0 and keeps bits 31:16. A high-half write replaces bits 31:16 and keeps bits 15:0.
- R2: Low-half writes to registers 0, 1, 2, 3, 4 and 7 are ANDed with 0xFFE0. High halves and both watermark halves take the written data unchanged.
- R3: On an accepted burst the producer position reloads the ring start if it equals the ring last slot, and otherwise grows by 32.
- R4: An accepted burst adds 32 to the byte count. A burst is accepted only while bit 0 of the control register (address 0x10, read and write) is 1. Otherwise it changes nothing.
- R5: The occupancy at addresses 0x12 (low) and 0x13 (high) reads producer minus consumer when producer >= consumer. Otherwise it reads (last slot - consumer) + (producer - start) + 32.
- R6: A high-half write to the byte count sets the restart pulse for exactly the next cycle. The gather-pipe restart pulse is also set in that cycle if the new 32-bit count is zero.
- R7: Addresses 0x18 to 0x1E read 0 and address 0x1F reads 4. Writes to them change nothing.
- R8: A consume strobe moves the consumer position in the same way as R3 and subtracts 32 from the byte count. It is ignored while the byte count is zero.
- R9: The overflow flag (address 0x11 bit 0) sets when a burst is accepted while the byte count equals last slot minus start. It then stays set until reset.
- R10: Synchronous reset clears all eight pointer registers, the control bit and the overflow flag, so every readable address except 0x1F reads 0.
- R11: When a bus write and a strobe touch the same register in one cycle, the bus write wins for that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register half-word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| burst_in | input | 1 | A 32-byte command block has arrived |
| consume_in | input | 1 | A 32-byte command block has been taken |
| dist_rst_pulse | output | 1 | Byte count was rewritten (high half) |
| pipe_rst_pulse | output | 1 | Byte count was rewritten to zero |

## Verification
On every cycle the assertions check that the producer position stays 32-byte aligned and steps or folds correctly on each accepted burst. They also check that an unlinked burst leaves it alone, that the count grows by 32 on a lone burst, and that consume strobes on an empty ring change nothing. Further checks cover the overflow flag, which must set on a burst into a full ring and never clear, and the gather-pipe pulse, which never appears without the restart pulse. The observable results come only from the bench's scenarios: the half-register merge and masking at the bus, the occupancy arithmetic over a long wrapping sweep, the constant counter addresses and the bus-over-strobe priority.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  localparam int HALF_W     = 16;
  localparam int PTR_W      = 2 * HALF_W;
  localparam int NUM_PTR    = 8;
  localparam int IDX_W      = $clog2(NUM_PTR);
  localparam int ADDR_W     = IDX_W + 2;
  localparam int ALIGN_LOG2 = 5;
  localparam int STEP       = 1 << ALIGN_LOG2;

  localparam int IX_BASE = 0;
  localparam int IX_LAST = 1;
  localparam int IX_WP   = 2;
  localparam int IX_RP   = 3;
  localparam int IX_DIST = 4;
  localparam int IX_HIWM = 5;
  localparam int IX_LOWM = 6;
  localparam int IX_BRK  = 7;

  localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'(5'h11);
  localparam logic [ADDR_W-1:0] A_OCC_LO   = ADDR_W'(5'h12);
  localparam logic [ADDR_W-1:0] A_OCC_HI   = ADDR_W'(5'h13);
  localparam logic [ADDR_W-1:0] A_CPV      = ADDR_W'(5'h1F);

  // Mask applied to low-half writes of register idx.
  function automatic logic [HALF_W-1:0] low_mask_for(input int idx);
    logic [HALF_W-1:0] align;
    align = ~HALF_W'((1 << ALIGN_LOG2) - 1);
    return (idx == IX_HIWM || idx == IX_LOWM) ? '1 : align;
  endfunction

  // Next ring slot: fold to start when at the last slot.
  function automatic logic [PTR_W-1:0] next_slot(input logic [PTR_W-1:0] cur,
                                                 input logic [PTR_W-1:0] start,
                                                 input logic [PTR_W-1:0] last);
    return (cur == last) ? start : cur + PTR_W'(STEP);
  endfunction

  // Bytes outstanding between consumer and producer, wrap compensated.
  function automatic logic [PTR_W-1:0] ring_occupancy(input logic [PTR_W-1:0] prod,
                                                      input logic [PTR_W-1:0] cons,
                                                      input logic [PTR_W-1:0] start,
                                                      input logic [PTR_W-1:0] last);
    if (prod >= cons) return prod - cons;
    return (last - cons) + (prod - start) + PTR_W'(STEP);
  endfunction
endpackage

// File: rtl/cmdring_half_reg.sv
module cmdring_half_reg #(
  parameter int HALF_W = 16,
  parameter logic [HALF_W-1:0] LO_MASK = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  input  logic                upd_en,
  input  logic [2*HALF_W-1:0] upd_val,
  output logic [2*HALF_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (wr_lo)  q <= {q[2*HALF_W-1:HALF_W], wdata & LO_MASK};
    else if (wr_hi)  q <= {wdata, q[HALF_W-1:0]};
    else if (upd_en) q <= upd_val;
  end
endmodule

// File: rtl/cmdring_engine.sv
module cmdring_engine
  import cmdring_pkg::*;
(
  input  logic [PTR_W-1:0] base_q,
  input  logic [PTR_W-1:0] last_q,
  input  logic [PTR_W-1:0] wp_q,
  input  logic [PTR_W-1:0] rp_q,
  input  logic [PTR_W-1:0] dist_q,
  input  logic             burst_take,
  input  logic             consume_take,
  output logic [PTR_W-1:0] wp_next,
  output logic [PTR_W-1:0] rp_next,
  output logic [PTR_W-1:0] dist_next,
  output logic             dist_chg,
  output logic             full_now,
  output logic [PTR_W-1:0] occupancy
);
  always_comb begin
    wp_next   = next_slot(wp_q, base_q, last_q);
    rp_next   = next_slot(rp_q, base_q, last_q);
    dist_chg  = burst_take ^ consume_take;
    dist_next = burst_take ? dist_q + PTR_W'(STEP) : dist_q - PTR_W'(STEP);
    full_now  = (dist_q == last_q - base_q);
    occupancy = ring_occupancy(wp_q, rp_q, base_q, last_q);
  end
endmodule

// File: rtl/cmdring_rd_mux.sv
module cmdring_rd_mux
  import cmdring_pkg::*;
#(
  parameter int CPV_VALUE = 4
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs,
  input  logic                          link_q,
  input  logic                          ovf_q,
  input  logic [PTR_W-1:0]              occupancy,
  output logic [HALF_W-1:0]             rdata
);
  logic [PTR_W-1:0] sel;
  always_comb begin
    sel   = ptrs[addr[IDX_W:1]];
    rdata = '0;
    if (!addr[ADDR_W-1]) begin
      rdata = addr[0] ? sel[PTR_W-1:HALF_W] : sel[HALF_W-1:0];
    end else begin
      case (addr)
        A_CTRL:   rdata = {{(HALF_W-1){1'b0}}, link_q};
        A_STAT:   rdata = {{(HALF_W-1){1'b0}}, ovf_q};
        A_OCC_LO: rdata = occupancy[HALF_W-1:0];
        A_OCC_HI: rdata = occupancy[PTR_W-1:HALF_W];
        A_CPV:    rdata = HALF_W'(CPV_VALUE);
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmdring_regs.sv
module cmdring_regs
  import cmdring_pkg::*;
#(
  parameter int CPV_VALUE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic [HALF_W-1:0] reg_rdata,
  input  logic              burst_in,
  input  logic              consume_in,
  output logic              dist_rst_pulse,
  output logic              pipe_rst_pulse
);
  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs;
  logic [NUM_PTR-1:0]            wr_lo, wr_hi, upd_en;
  logic [NUM_PTR-1:0][PTR_W-1:0] upd_val;
  logic [PTR_W-1:0] wp_next, rp_next, dist_next, occupancy;
  logic             dist_chg, full_now;
  logic             link_q, ovf_q;
  logic             ptr_space;

  // Named internal events
  logic burst_take, consume_take, overflow_evt;

  assign ptr_space    = reg_wr && !reg_addr[ADDR_W-1];
  assign burst_take   = burst_in && link_q;
  assign consume_take = consume_in && (ptrs[IX_DIST] != '0);
  assign overflow_evt = burst_take && full_now;

  for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
    assign wr_lo[gi] = ptr_space && (reg_addr[IDX_W:1] == IDX_W'(gi)) && !reg_addr[0];
    assign wr_hi[gi] = ptr_space && (reg_addr[IDX_W:1] == IDX_W'(gi)) &&  reg_addr[0];
    cmdring_half_reg #(
      .HALF_W (HALF_W),
      .LO_MASK(low_mask_for(gi))
    ) u_reg (
      .clk    (clk),
      .rst    (rst),
      .wr_lo  (wr_lo[gi]),
      .wr_hi  (wr_hi[gi]),
      .wdata  (reg_wdata),
      .upd_en (upd_en[gi]),
      .upd_val(upd_val[gi]),
      .q      (ptrs[gi])
    );
  end

  cmdring_engine u_engine (
    .base_q      (ptrs[IX_BASE]),
    .last_q      (ptrs[IX_LAST]),
    .wp_q        (ptrs[IX_WP]),
    .rp_q        (ptrs[IX_RP]),
    .dist_q      (ptrs[IX_DIST]),
    .burst_take  (burst_take),
    .consume_take(consume_take),
    .wp_next     (wp_next),
    .rp_next     (rp_next),
    .dist_next   (dist_next),
    .dist_chg    (dist_chg),
    .full_now    (full_now),
    .occupancy   (occupancy)
  );

  always_comb begin
    upd_en           = '0;
    upd_val          = '0;
    upd_en[IX_WP]    = burst_take;
    upd_val[IX_WP]   = wp_next;
    upd_en[IX_RP]    = consume_take;
    upd_val[IX_RP]   = rp_next;
    upd_en[IX_DIST]  = dist_chg;
    upd_val[IX_DIST] = dist_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_q         <= 1'b0;
      ovf_q          <= 1'b0;
      dist_rst_pulse <= 1'b0;
      pipe_rst_pulse <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) link_q <= reg_wdata[0];
      if (overflow_evt) ovf_q <= 1'b1;
      dist_rst_pulse <= wr_hi[IX_DIST];
      pipe_rst_pulse <= wr_hi[IX_DIST] &&
                        ({reg_wdata, ptrs[IX_DIST][HALF_W-1:0]} == '0);
    end
  end

  cmdring_rd_mux #(.CPV_VALUE(CPV_VALUE)) u_rd (
    .addr     (reg_addr),
    .ptrs     (ptrs),
    .link_q   (link_q),
    .ovf_q    (ovf_q),
    .occupancy(occupancy),
    .rdata    (reg_rdata)
  );
endmodule

// File: rtl/cmdring_regs_chk.sv
module cmdring_regs_chk
  import cmdring_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              burst_in,
  input logic              burst_take,
  input logic              consume_take,
  input logic              link_q,
  input logic              ovf_q,
  input logic [PTR_W-1:0]  base_q,
  input logic [PTR_W-1:0]  last_q,
  input logic [PTR_W-1:0]  wp_q,
  input logic [PTR_W-1:0]  rp_q,
  input logic [PTR_W-1:0]  dist_q,
  input logic              dist_rst_pulse,
  input logic              pipe_rst_pulse
);
  logic wp_bus, rp_bus, dist_bus;
  assign wp_bus   = reg_wr && reg_addr[ADDR_W-1:1] == (ADDR_W-1)'(IX_WP);
  assign rp_bus   = reg_wr && reg_addr[ADDR_W-1:1] == (ADDR_W-1)'(IX_RP);
  assign dist_bus = reg_wr && reg_addr[ADDR_W-1:1] == (ADDR_W-1)'(IX_DIST);

  AST_WP_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    wp_q[ALIGN_LOG2-1:0] == '0); // R2
  AST_WP_STEP: assert property (@(posedge clk) disable iff (rst)
    burst_take && !wp_bus |=>
      wp_q == (($past(wp_q) == $past(last_q)) ? $past(base_q) : $past(wp_q) + PTR_W'(STEP))); // R3
  AST_UNLINKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    burst_in && !link_q && !wp_bus |=> $stable(wp_q)); // R4
  AST_DIST_GROW: assert property (@(posedge clk) disable iff (rst)
    burst_take && !consume_take && !dist_bus |=> dist_q == $past(dist_q) + PTR_W'(STEP)); // R4
  AST_EMPTY_NO_CONSUME: assert property (@(posedge clk) disable iff (rst)
    dist_q == '0 && !rp_bus |-> !consume_take); // R8
  AST_PIPE_WITH_DIST: assert property (@(posedge clk) disable iff (rst)
    pipe_rst_pulse |-> dist_rst_pulse); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    burst_take && dist_q == last_q - base_q |=> ovf_q); // R9
  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q); // R9
  AST_RP_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !consume_take && !rp_bus |=> $stable(rp_q)); // R8
endmodule

bind cmdring_regs cmdring_regs_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .burst_in      (burst_in),
  .burst_take    (burst_take),
  .consume_take  (consume_take),
  .link_q        (link_q),
  .ovf_q         (ovf_q),
  .base_q        (ptrs[0]),
  .last_q        (ptrs[1]),
  .wp_q          (ptrs[2]),
  .rp_q          (ptrs[3]),
  .dist_q        (ptrs[4]),
  .dist_rst_pulse(dist_rst_pulse),
  .pipe_rst_pulse(pipe_rst_pulse)
);

// File: tb/test_cmdring_regs.sv
`timescale 1ns/1ps
module test_cmdring_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        burst_in = 1'b0, consume_in = 1'b0;
  logic        dist_rst_pulse, pipe_rst_pulse;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  cmdring_regs i_cmdring_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .burst_in(burst_in),
    .consume_in(consume_in), .dist_rst_pulse(dist_rst_pulse),
    .pipe_rst_pulse(pipe_rst_pulse)
  );

  // Register addresses (k*2 low, k*2+1 high)
  localparam logic [4:0] BASE = 5'd0, LAST = 5'd2, WP = 5'd4, RP = 5'd6,
                         DIST = 5'd8, HIWM = 5'd10, LOWM = 5'd12, BRK = 5'd14,
                         CTRL = 5'h10, STAT = 5'h11, OCC = 5'h12;

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wr32(input logic [4:0] a, input logic [31:0] d);
    wr(a, d[15:0]); wr(a + 5'd1, d[31:16]);
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd32(input logic [4:0] a, output logic [31:0] d);
    logic [15:0] lo, hi;
    rd(a, lo); rd(a + 5'd1, hi); d = {hi, lo};
  endtask

  task automatic strobe(input bit b, input bit c);
    @(negedge clk); burst_in = b; consume_in = c;
    @(negedge clk); burst_in = 1'b0; consume_in = 1'b0;
  endtask

  // Bench ring model
  logic [31:0] m_base, m_last, m_wp, m_rp, m_dist;

  function automatic logic [31:0] adv(input logic [31:0] p);
    logic [31:0] off;
    off = p - m_base + 32;
    if (off > m_last - m_base) off = 0;
    return m_base + off;
  endfunction

  function automatic logic [31:0] occ_model();
    logic [31:0] ring;
    ring = m_last - m_base + 32;
    return (m_wp >= m_rp) ? m_wp - m_rp : ring - (m_rp - m_wp);
  endfunction

  task automatic setup_ring(input logic [31:0] b, input logic [31:0] l);
    m_base = b; m_last = l; m_wp = b; m_rp = b; m_dist = 0;
    wr32(BASE, b); wr32(LAST, l); wr32(WP, b); wr32(RP, b); wr32(DIST, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] h;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state, all readable addresses zero
    for (int a = 0; a < 20; a++) begin
      rd(5'(a), h); check("R10 reset read", h, 0);
    end
    check("R10 restart pulse idle", dist_rst_pulse, 0);

    // R7: counter block constants, unchanged by writes
    for (int a = 24; a < 32; a++) begin
      wr(5'(a), 16'hBEEF);
      rd(5'(a), h); check("R7 counter const", h, (a == 31) ? 4 : 0);
    end

    // R1: half merge
    wr(HIWM, 16'h1234); wr(HIWM + 5'd1, 16'hABCD);
    rd32(HIWM, w); check("R1 merge hi keeps lo", w, 32'hABCD1234);
    wr(HIWM, 16'h5678);
    rd32(HIWM, w); check("R1 merge lo keeps hi", w, 32'hABCD5678);

    // R2: masking per register
    for (int k = 0; k < 8; k++) begin
      wr(5'(2*k), 16'hFFFF); wr(5'(2*k+1), 16'hFFFF);
      rd32(5'(2*k), w);
      check("R2 low mask", w, (k == 5 || k == 6) ? 32'hFFFF_FFFF : 32'hFFFF_FFE0);
    end

    // Ring with 9 slots spanning the upper half-word
    setup_ring(32'h0001_0100, 32'h0001_0200);
    // R4: burst ignored while link clear
    strobe(1, 0);
    rd32(WP, w); check("R4 unlinked burst wp", w, m_wp);
    rd32(DIST, w); check("R4 unlinked burst dist", w, 0);
    wr(CTRL, 16'h0001);
    rd(CTRL, h); check("R4 link bit readback", h, 1);

    // R8: consume on empty ring ignored
    strobe(0, 1);
    rd32(RP, w); check("R8 empty consume rp", w, m_rp);

    // Sweep R3 R4 R5 R8 through many wraps
    for (int s = 0; s < 400; s++) begin
      bit b, c;
      logic [31:0] d0;
      b = ((s % 5) != 1) && (m_dist < m_last - m_base);
      c = ((s % 3) == 0) || ((s % 7) == 2) || (m_dist == m_last - m_base);
      strobe(b, c);
      d0 = m_dist;
      if (b) begin m_wp = adv(m_wp); m_dist += 32; end
      if (c && d0 != 0) begin m_rp = adv(m_rp); m_dist -= 32; end
      rd32(WP, w);   check("R3 producer step", w, m_wp);
      rd32(RP, w);   check("R8 consumer step", w, m_rp);
      rd32(DIST, w); check("R4 byte count", w, m_dist);
      rd32(OCC, w);  check("R5 occupancy", w, occ_model());
    end
    rd(STAT, h); check("R9 no overflow in sweep", h, 0);

    // R5: explicit wrapped occupancy
    m_wp = m_base + 32'h40; m_rp = m_last - 32'h20;
    wr32(WP, m_wp); wr32(RP, m_rp);
    rd32(OCC, w); check("R5 wrapped occupancy", w, 32'h80);
    check("R5 wrapped occupancy model", w, occ_model());

    // R11: bus write beats burst on producer
    @(negedge clk); reg_wr = 1; reg_addr = WP; reg_wdata = 16'h0180; burst_in = 1;
    @(negedge clk); reg_wr = 0; burst_in = 0;
    rd32(WP, w); check("R11 bus wins producer", w, 32'h0001_0180);
    rd32(DIST, w); check("R11 count still grows", w, m_dist + 32);

    // R6: restart pulses
    @(negedge clk); reg_wr = 1; reg_addr = DIST + 5'd1; reg_wdata = 16'h0001;
    @(negedge clk); reg_wr = 0;
    check("R6 restart pulse", dist_rst_pulse, 1);
    check("R6 no pipe pulse nonzero", pipe_rst_pulse, 0);
    @(negedge clk);
    check("R6 pulse one cycle", dist_rst_pulse, 0);
    wr(DIST, 16'h0000);
    @(negedge clk); reg_wr = 1; reg_addr = DIST + 5'd1; reg_wdata = 16'h0000;
    @(negedge clk); reg_wr = 0;
    check("R6 restart pulse zero", dist_rst_pulse, 1);
    check("R6 pipe pulse zero", pipe_rst_pulse, 1);
    @(negedge clk);
    check("R6 pipe pulse one cycle", pipe_rst_pulse, 0);

    // R9: overflow on burst into full ring, sticky
    setup_ring(32'h0000_0400, 32'h0000_0500);
    for (int i = 0; i < 8; i++) strobe(1, 0);
    rd(STAT, h); check("R9 full but no overflow", h, 0);
    strobe(1, 0);
    rd(STAT, h); check("R9 overflow set", h, 1);
    for (int i = 0; i < 4; i++) strobe(0, 1);
    rd(STAT, h); check("R9 overflow sticky", h, 1);

    // R10: reset clears again
    @(negedge clk); rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    rd(STAT, h); check("R10 overflow cleared", h, 0);
    rd32(LAST, w); check("R10 last cleared", w, 0);
    rd(CTRL, h); check("R10 link cleared", h, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule